// File: doc/BRIEF.md
# Frame-Sync Superframe Codec

This block carries superframe alignment inside the width of the frame-sync pulse on a GCI-style serial link. Every frame on the link begins with a frame-sync pulse at bit 0. An ordinary pulse lasts two bit clocks. A pulse that lasts only one bit clock marks the frame that holds the first 2B+D block of a 96-frame superframe. No separate alignment wire is needed.

In master role the block drives frame sync itself. It emits a two-clock pulse in each frame. When the receive path reports a superframe start, the pulse of the next frame is shortened to one clock, so the far end sees where the received superframe begins. In slave role the block measures each incoming pulse. A one-clock pulse forces the transmit frame index to 0, so the data taken in during that frame becomes the first transmitted block. A two-clock pulse only advances the index. Any other width sets a sticky error and leaves alignment as it was. If no marker ever arrives, the index wraps on its own and the transmit superframe aligns itself.

Top module: `frame_sync_sf_codec`

## Requirements
- R1: In master role `fs_oe` is 1. Frame sync rises at bit 0 of every frame of `FRAME_LEN` bit clocks, and an ordinary pulse is high for exactly two bit clocks.
- R2: In master role, a one-clock `rx_sf_start` request sampled at any bit of a frame makes the following frame's sync pulse one bit clock wide. Only that single frame is shortened, and later frames return to two clocks.
- R3: In master role `tx_frame_idx` moves up by one at the clock edge that closes bit 0 of each frame, wrapping from 95 to 0. `tx_sf_start` is high for the one clock in which the index has just become 0.
- R4: In slave role `fs_oe` and `fs_out` are 0. A received two-clock pulse advances `tx_frame_idx` by one at the clock edge where `fs_in` is first sampled low after the pulse.
- R5: In slave role a received one-clock pulse forces `tx_frame_idx` to 0 at that same edge, whatever its previous value, and raises `tx_sf_start` for one clock.
- R6: In slave role with no marker, a normal pulse that arrives while the index is 95 wraps it to 0 and raises `tx_sf_start`, so the superframe aligns itself.
- R7: In slave role a received pulse of width 3 or more sets `fs_width_err`. The flag stays set until reset, and the index advances by one as for a normal frame.
- R8: `align_marker_in` has no effect on any output in either role.
- R9: In master role `fs_in` has no effect, and a short pulse on it neither realigns the index nor raises the error flag.
- R10: While `rst_n` is low and directly after reset: `fs_out`=0, `tx_sf_start`=0, `fs_width_err`=0, and `tx_frame_idx`=95.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| is_master | input | 1 | 1 = drive frame sync, 0 = receive it |
| fs_in | input | 1 | Frame sync received from the link (slave role) |
| align_marker_in | input | 1 | Separate alignment marker; ignored in this format |
| rx_sf_start | input | 1 | Receive path reports the first 2B+D block of the superframe |
| fs_out | output | 1 | Frame sync driven onto the link (master role) |
| fs_oe | output | 1 | Output enable for the frame-sync pin |
| tx_sf_start | output | 1 | One-clock strobe when the transmit index becomes 0 |
| tx_frame_idx | output | 7 | Transmit frame index within the superframe, 0 to 95 |
| fs_width_err | output | 1 | Sticky flag: a received pulse had an illegal width |

## Verification
The bench aims at the edges of the width decoder. It sends one-, two-, three- and four-clock pulses. A decoder that counted one clock too many or too few would treat markers as normal frames, and normal frames as errors. It raises the marker request both at the last bit of a frame and inside the frame. A master that latched the request late would shorten the wrong frame, and one that failed to clear it would shorten two frames in a row. It also runs the index through its 95-to-0 wrap in both roles, and it sends a bad width after alignment is established. A design that realigned on an error, or let the error flag drop again, would show a wrong index or a cleared flag at the end of the following frames.

// File: rtl/fsc_pkg.sv
// Package: shared types for the frame-sync superframe codec.
package fsc_pkg;
    // Classification of a completed frame-sync pulse seen on the input pin.
    typedef enum logic [1:0] {
        FS_NONE   = 2'd0,
        FS_NORMAL = 2'd1,
        FS_MARKER = 2'd2,
        FS_BAD    = 2'd3
    } fs_class_e;
endpackage

// File: rtl/fsc_width_decoder.sv
// Module: fsc_width_decoder
// Measures the width of each frame-sync pulse received in slave role.
// It reports the class of the pulse during the one clock in which the pin
// is first sampled low after being high.
// Assumes fs_in is synchronous to clk. Widths above 3 saturate to 3.
module fsc_width_decoder
    import fsc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      fs_in,
    output fs_class_e pulse_class
);
    localparam int CNT_W = 2;
    localparam logic [CNT_W-1:0] CNT_SAT = '1;

    logic             fs_prev;
    logic [CNT_W-1:0] width_cnt;

    // Track the previous pin level and count the clocks the pin stays high.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            fs_prev   <= 1'b0;
            width_cnt <= '0;
        end else begin
            fs_prev <= fs_in;
            if (fs_in) begin
                if (!fs_prev)
                    width_cnt <= CNT_W'(1);
                else if (width_cnt != CNT_SAT)
                    width_cnt <= width_cnt + CNT_W'(1);
            end
        end
    end

    // Classify the pulse on its falling edge.
    always_comb begin
        pulse_class = FS_NONE;
        if (enable && fs_prev && !fs_in) begin
            case (width_cnt)
                CNT_W'(1): pulse_class = FS_MARKER;
                CNT_W'(2): pulse_class = FS_NORMAL;
                default:   pulse_class = FS_BAD;
            endcase
        end
    end
endmodule

// File: rtl/fsc_frame_timer.sv
// Module: fsc_frame_timer
// Bit counter and frame-sync generator for master role. A pulse starts at
// bit 0 of each frame. It lasts two clocks, or one clock when a
// receive-superframe request was seen during the previous frame.
// Assumes FRAME_LEN >= 4. After reset the counter sits at the last bit, so
// the first frame starts one clock after reset is released.
module fsc_frame_timer #(
    parameter int FRAME_LEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_sf_start,
    output logic fs_drive,
    output logic frame_start
);
    localparam int BIT_W = $clog2(FRAME_LEN);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_LEN - 1);

    logic [BIT_W-1:0] bit_cnt;
    logic             req_pending;
    logic             short_frame;

    // Advance the bit position within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bit_cnt <= LAST_BIT;
        else if (bit_cnt == LAST_BIT)
            bit_cnt <= '0;
        else
            bit_cnt <= bit_cnt + BIT_W'(1);
    end

    // Collect marker requests and commit them to the next frame at its boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_pending <= 1'b0;
            short_frame <= 1'b0;
        end else if (bit_cnt == LAST_BIT) begin
            short_frame <= req_pending | rx_sf_start;
            req_pending <= 1'b0;
        end else begin
            req_pending <= req_pending | rx_sf_start;
        end
    end

    // Shape the pulse: bit 0 always, bit 1 only for an ordinary frame.
    always_comb begin
        frame_start = (bit_cnt == '0);
        fs_drive    = frame_start || ((bit_cnt == BIT_W'(1)) && !short_frame);
    end
endmodule

// File: rtl/fsc_sf_index.sv
// Module: fsc_sf_index
// Transmit frame index within the superframe. It steps on each frame event
// and wraps at SF_FRAMES-1. A force request loads 0 instead. sf_start is a
// one-clock strobe when the index has just become 0.
// Assumes force_zero is only meaningful together with advance.
module fsc_sf_index #(
    parameter int SF_FRAMES = 96,
    parameter int IDX_W     = $clog2(SF_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             force_zero,
    output logic [IDX_W-1:0] idx,
    output logic             sf_start
);
    localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(SF_FRAMES - 1);

    // Step, wrap or force the index and flag entry to frame 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= IDX_MAX;
            sf_start <= 1'b0;
        end else begin
            sf_start <= 1'b0;
            if (advance) begin
                if (force_zero || idx == IDX_MAX) begin
                    idx      <= '0;
                    sf_start <= 1'b1;
                end else begin
                    idx <= idx + IDX_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/frame_sync_sf_codec.sv
// Module: frame_sync_sf_codec (top)
// Encodes and decodes superframe alignment in the frame-sync pulse width.
// In master role a timer drives the pin, and the index free-runs on frame
// starts. In slave role a decoder classifies each received pulse: a
// one-clock pulse realigns the index, a two-clock pulse advances it, and any
// other width sets a sticky error. The separate marker input is unused in
// this format. Assumes all inputs are synchronous to clk.
module frame_sync_sf_codec
    import fsc_pkg::*;
#(
    parameter int FRAME_LEN = 32,
    parameter int SF_FRAMES = 96,
    localparam int IDX_W    = $clog2(SF_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_master,
    input  logic             fs_in,
    input  logic             align_marker_in,
    input  logic             rx_sf_start,
    output logic             fs_out,
    output logic             fs_oe,
    output logic             tx_sf_start,
    output logic [IDX_W-1:0] tx_frame_idx,
    output logic             fs_width_err
);
    logic      tmr_fs;
    logic      tmr_frame_start;
    fs_class_e rx_class;
    logic      idx_advance;
    logic      idx_force;
    logic      unused_marker;

    assign unused_marker = align_marker_in;

    fsc_frame_timer #(.FRAME_LEN(FRAME_LEN)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_sf_start (rx_sf_start & is_master),
        .fs_drive    (tmr_fs),
        .frame_start (tmr_frame_start)
    );

    fsc_width_decoder u_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (!is_master),
        .fs_in       (fs_in),
        .pulse_class (rx_class)
    );

    // Pick the frame event and realign request for the active role.
    always_comb begin
        if (is_master) begin
            idx_advance = tmr_frame_start;
            idx_force   = 1'b0;
        end else begin
            idx_advance = (rx_class != FS_NONE);
            idx_force   = (rx_class == FS_MARKER);
        end
    end

    fsc_sf_index #(.SF_FRAMES(SF_FRAMES), .IDX_W(IDX_W)) u_index (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (idx_advance),
        .force_zero (idx_force),
        .idx        (tx_frame_idx),
        .sf_start   (tx_sf_start)
    );

    // Latch an illegal received width until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fs_width_err <= 1'b0;
        else if (rx_class == FS_BAD)
            fs_width_err <= 1'b1;
    end

    // Drive the pin only in master role.
    always_comb begin
        fs_oe  = is_master;
        fs_out = is_master && rst_n && tmr_fs;
    end
endmodule

// File: rtl/fsc_sf_checker.sv
// Module: fsc_sf_checker
// Temporal properties of the frame-sync superframe codec, bound to the top.
module fsc_sf_checker #(
    parameter int SF_FRAMES = 96,
    localparam int IDX_W    = $clog2(SF_FRAMES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             is_master,
    input logic             fs_out,
    input logic             tx_sf_start,
    input logic [IDX_W-1:0] tx_frame_idx,
    input logic             fs_width_err
);
    // No driven pulse is ever longer than two clocks.
    assert_fs_max_two_R1: assert property (@(posedge clk)
        disable iff (!rst_n || !is_master)
        (fs_out && $past(fs_out)) |=> !fs_out);

    // The index stays inside the superframe.
    assert_idx_in_range_R3: assert property (@(posedge clk)
        disable iff (!rst_n)
        tx_frame_idx < IDX_W'(SF_FRAMES));

    // The start strobe only appears with index 0.
    assert_sf_start_at_zero_R5: assert property (@(posedge clk)
        disable iff (!rst_n)
        tx_sf_start |-> (tx_frame_idx == '0));

    // Any index change is a step by one or a jump to 0.
    assert_idx_step_R4: assert property (@(posedge clk)
        disable iff (!rst_n)
        (tx_frame_idx != $past(tx_frame_idx)) |->
            (tx_frame_idx == '0 || tx_frame_idx == $past(tx_frame_idx) + IDX_W'(1)));

    // The width error never clears on its own.
    assert_err_sticky_R7: assert property (@(posedge clk)
        disable iff (!rst_n)
        fs_width_err |=> fs_width_err);

    // Slave role never drives the pin.
    assert_slave_quiet_R4: assert property (@(posedge clk)
        disable iff (!rst_n)
        !is_master |-> !fs_out);
endmodule

bind frame_sync_sf_codec fsc_sf_checker #(.SF_FRAMES(SF_FRAMES)) u_fsc_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .is_master    (is_master),
    .fs_out       (fs_out),
    .tx_sf_start  (tx_sf_start),
    .tx_frame_idx (tx_frame_idx),
    .fs_width_err (fs_width_err)
);

// File: tb/frame_sync_sf_codec_bench.sv
// Bench for frame_sync_sf_codec: a scoreboard of expected master pulse widths
// plus per-frame index checks in both roles.
module frame_sync_sf_codec_bench;
    localparam int FL  = 32;
    localparam int SFN = 96;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       is_master = 1'b1;
    logic       fs_in = 1'b0;
    logic       align_marker_in = 1'b0;
    logic       rx_sf_start = 1'b0;
    logic       fs_out, fs_oe, tx_sf_start, fs_width_err;
    logic [6:0] tx_frame_idx;

    int vec_cnt = 0;
    int bad_cnt = 0;
    int exp_q[$];
    bit mon_en = 1'b0;
    int mon_w = 0;
    int m_idx = 0;
    int s_idx = 95;
    bit s_err = 1'b0;

    frame_sync_sf_codec #(.FRAME_LEN(FL), .SF_FRAMES(SFN)) u_frame_sync_sf_codec (
        .clk(clk), .rst_n(rst_n), .is_master(is_master), .fs_in(fs_in),
        .align_marker_in(align_marker_in), .rx_sf_start(rx_sf_start),
        .fs_out(fs_out), .fs_oe(fs_oe), .tx_sf_start(tx_sf_start),
        .tx_frame_idx(tx_frame_idx), .fs_width_err(fs_width_err)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vec_cnt++;
        if (!ok) begin
            bad_cnt++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: measure each driven pulse and compare with the scoreboard.
    always @(negedge clk) begin
        if (mon_en) begin
            if (fs_out) begin
                mon_w++;
            end else if (mon_w > 0) begin
                if (exp_q.size() == 0)
                    check(1'b0, "R2 unexpected pulse", mon_w, 0);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    check(mon_w == e, "R1 R2 pulse width", mon_w, e);
                end
                mon_w = 0;
            end
        end
    end

    task automatic do_reset(input bit master);
        is_master = master;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(fs_out == 1'b0, "R10 fs_out in reset", fs_out, 0);
        check(tx_frame_idx == 7'd95, "R10 index in reset", tx_frame_idx, 95);
        check(tx_sf_start == 1'b0, "R10 sf_start in reset", tx_sf_start, 0);
        check(fs_width_err == 1'b0, "R10 error in reset", fs_width_err, 0);
        check(fs_oe == master, "R1 R4 fs_oe", fs_oe, master);
        rst_n = 1'b1;
    endtask

    // Driver for one master frame, entered at the negedge inside bit 0.
    task automatic master_frame(input bit mark, input int at_bit, input bit noisy);
        for (int b = 0; b < FL; b++) begin
            if (b == 0) check(fs_out == 1'b1, "R1 pulse at bit 0", fs_out, 1);
            if (b == 1) check(tx_sf_start == (m_idx == 0), "R3 sf_start", tx_sf_start, m_idx == 0);
            if (b == 5) check(tx_frame_idx == m_idx, "R3 R8 R9 master index", tx_frame_idx, m_idx);
            if (b == 5) check(fs_width_err == 1'b0, "R9 no error in master", fs_width_err, 0);
            rx_sf_start     = mark && (b == at_bit);
            fs_in           = noisy && (b == 0);
            align_marker_in = noisy && (b == 1);
            @(negedge clk);
        end
        rx_sf_start = 1'b0;
        exp_q.push_back(mark ? 1 : 2);
        m_idx = (m_idx + 1) % SFN;
    endtask

    // Driver for one slave frame carrying a received pulse of width w.
    task automatic slave_frame(input int w, input string tag);
        bit start_exp;
        start_exp = (w == 1) || (s_idx == SFN - 1);
        if (w == 1) s_idx = 0;
        else s_idx = (s_idx + 1) % SFN;
        if (w >= 3) s_err = 1'b1;
        for (int b = 0; b < FL; b++) begin
            if (b == w + 1) begin
                check(tx_frame_idx == s_idx, {tag, " slave index"}, tx_frame_idx, s_idx);
                check(tx_sf_start == start_exp, {tag, " slave sf_start"}, tx_sf_start, start_exp);
            end
            if (b == FL - 1) begin
                check(fs_width_err == s_err, "R7 sticky error", fs_width_err, s_err);
                check(fs_out == 1'b0 && fs_oe == 1'b0, "R4 slave pin idle", fs_out, 0);
            end
            fs_in           = (b < w);
            align_marker_in = (b == 3) || (b == w);
            @(negedge clk);
        end
    endtask

    initial begin
        #1000000;
        check(1'b0, "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end

    initial begin
        @(negedge clk);
        // Master role: R1 R2 R3 R8 R9
        do_reset(1'b1);
        exp_q.push_back(2);
        mon_en = 1'b1;
        do @(negedge clk); while (!fs_out);
        m_idx = 0;
        for (int f = 0; f < 100; f++) begin
            bit mark;
            mark = (f == 3) || (f == 10) || (f == 50) || (f == 51);
            master_frame(mark, (f == 10) ? FL - 1 : (f * 7) % FL, (f % 3) == 0);
        end
        mon_en = 1'b0;
        mon_w = 0;
        exp_q.delete();

        // Slave role: R4 R5 R6 R7 R8
        do_reset(1'b0);
        s_idx = 95;
        s_err = 1'b0;
        repeat (4) @(negedge clk);
        slave_frame(2, "R6");
        for (int f = 0; f < 4; f++) slave_frame(2, "R4");
        slave_frame(1, "R5");
        slave_frame(2, "R4");
        slave_frame(1, "R5");
        slave_frame(3, "R7");
        slave_frame(2, "R4");
        slave_frame(4, "R7");
        slave_frame(1, "R5");
        for (int f = 0; f < 98; f++) slave_frame(2, "R6");
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end
endmodule